// File: doc/BRIEF.md
# Masked interrupt collector

This block merges eight interrupt causes of a serial bus controller into one level-high interrupt line for software. Five of the causes are watermark comparisons on FIFO fill levels. They follow the level on their own. Three are sticky event flags: a receipt flag, an in-band interrupt flag and an address-request flag. Each sticky flag is set by a one-cycle event pulse and stays set until a specific clearing condition holds.

Software reaches the block through a small register port with three views. The source view is read-only and shows the raw state of all eight causes. The enable view can be read and written and holds one bit per cause. The pending view shows source AND enable; writing 1 to a bit of this view is the acknowledge.

The acknowledge only works when the FIFO behind the flag has been drained. The address-request flag ignores the acknowledge. It clears once a reply has been placed in the outgoing data FIFO. The interrupt output is registered and goes high when any pending bit is set.

Top module: `intr_collector`

## Requirements
- R1: The bit positions in every view, LSB first, are: 0 command FIFO low, 1 receipt FIFO high, 2 outgoing data FIFO low, 3 incoming data FIFO high, 4 in-band FIFO high, 5 receipt flag, 6 in-band flag, 7 address-request flag. The views are selected by `reg_addr`: 0 source, 1 enable, 2 pending, 3 reads as zero.
- R2: After a synchronous active-low reset, `irq` is 0, the enable view reads 0 and all three sticky flags are 0.
- R3: Bit 0 is 1 when `cmd_level < CMD_LOW`, and bit 2 is 1 when `tx_level < TX_LOW`. Each bit appears in the source view one clock after the level is sampled. A level equal to its threshold gives 0.
- R4: Bits 1, 3 and 4 are 1 when `rcpt_level > RCPT_HIGH`, `rx_level > RX_HIGH` and `ibi_level > IBI_HIGH`. Each bit appears in the source view one clock later. A level equal to its threshold gives 0.
- R5: A high `rcpt_event` sets bit 5, and a high `ibi_event` sets bit 6. The bit is set from the clock edge at which the pulse is sampled and stays set until it is cleared.
- R6: Writing the pending view (`reg_addr`=2) with bit 5 or bit 6 set clears that flag only if `rcpt_empty` or `ibi_empty`, in that order, is 1 at that edge. Otherwise the flag stays set.
- R7: An event sampled at the same edge as a clear condition wins, and the flag stays set.
- R8: Bit 7 clears at any edge where `tx_empty` is 0. Writing 1 to bits 0 to 4 or bit 7 of the pending view has no effect on the source view.
- R9: The enable view holds the last value written to `reg_addr`=1. The pending view reads source AND enable.
- R10: `irq` equals the OR of the pending bits, delayed by one clock. With all enable bits at 0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | View select: 0 source, 1 enable, 2 pending |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected view, combinational |
| cmd_level | input | LVL_W | Command FIFO fill level |
| rcpt_level | input | LVL_W | Receipt FIFO fill level |
| tx_level | input | LVL_W | Outgoing data FIFO fill level |
| rx_level | input | LVL_W | Incoming data FIFO fill level |
| ibi_level | input | LVL_W | In-band interrupt FIFO fill level |
| rcpt_empty | input | 1 | Receipt FIFO empty |
| ibi_empty | input | 1 | In-band interrupt FIFO empty |
| tx_empty | input | 1 | Outgoing data FIFO empty |
| rcpt_event | input | 1 | A new receipt word arrived |
| ibi_event | input | 1 | A new in-band interrupt word arrived |
| addr_req_event | input | 1 | A target requested a dynamic address |
| irq | output | 1 | Registered level-high interrupt |

## Verification
The assertions take for granted that every input is synchronous to `clk` and holds a defined value at each sampling edge once reset is released. The threshold checks also assume that the level inputs are plain binary counts. The bench meets these conditions by changing inputs only one nanosecond after a falling edge, so each value is stable well before the next rising edge. The random phase draws levels only from the full binary range of `LVL_W`. Event pulses, writes and empty flags are drawn at rates that make an event and an acknowledge often land on the same edge.

// File: rtl/intr_collector_pkg.sv
// Shared constants and the register view encoding for the interrupt collector.
// Assumes exactly eight causes: five watermarks in bits 0..4, three sticky flags above them.
package intr_collector_pkg;

    localparam int NUM_SRC  = 8;
    localparam int NUM_WM   = 5;
    localparam int NUM_FLAG = NUM_SRC - NUM_WM;

    // Source bit positions, LSB first
    localparam int B_CMD_LOW   = 0;
    localparam int B_RCPT_HIGH = 1;
    localparam int B_TX_LOW    = 2;
    localparam int B_RX_HIGH   = 3;
    localparam int B_IBI_HIGH  = 4;
    localparam int B_RCPT_FLAG = 5;
    localparam int B_IBI_FLAG  = 6;
    localparam int B_ADDR_FLAG = 7;

    // Watermarks that compare "above" (1) rather than "below" (0)
    localparam logic [NUM_WM-1:0] WM_ABOVE = 5'b11010;

    typedef enum logic [1:0] {
        VIEW_SRC  = 2'd0,
        VIEW_MASK = 2'd1,
        VIEW_PEND = 2'd2,
        VIEW_NONE = 2'd3
    } view_e;

endpackage

// File: rtl/intr_wm_cmp.sv
// One registered FIFO watermark comparison.
// ABOVE=1 flags level > THRESH, ABOVE=0 flags level < THRESH; equality never flags.
// Assumes the level input is synchronous to clk.
module intr_wm_cmp #(
    parameter int              LVL_W  = 6,
    parameter logic [LVL_W-1:0] THRESH = '0,
    parameter bit              ABOVE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    output logic             hit_q
);

    logic hit_d;

    generate
        if (ABOVE) begin : g_above
            // compare for an almost-full condition
            always_comb hit_d = (level > THRESH);
        end else begin : g_below
            // compare for an almost-empty condition
            always_comb hit_d = (level < THRESH);
        end
    endgenerate

    // register the comparison so the source view is glitch free
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

endmodule

// File: rtl/intr_evt_flag.sv
// Sticky event flag: set by an event pulse, cleared by a qualified clear.
// A set and a clear sampled at the same edge leave the flag set.
module intr_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    // hold the flag with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

endmodule

// File: rtl/intr_collector.sv
// Masked interrupt collector: five watermark causes and three sticky flags are
// gathered into a source vector, gated by an enable register, and OR-ed into a
// registered interrupt. The pending view takes a write-1 acknowledge for the
// receipt and in-band flags, which only works while their FIFO is empty. The
// address-request flag clears when the outgoing data FIFO holds data.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module intr_collector
    import intr_collector_pkg::*;
#(
    parameter int LVL_W     = 6,
    parameter int CMD_LOW   = 4,
    parameter int RCPT_HIGH = 28,
    parameter int TX_LOW    = 4,
    parameter int RX_HIGH   = 28,
    parameter int IBI_HIGH  = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [LVL_W-1:0]   cmd_level,
    input  logic [LVL_W-1:0]   rcpt_level,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   ibi_level,
    input  logic               rcpt_empty,
    input  logic               ibi_empty,
    input  logic               tx_empty,
    input  logic               rcpt_event,
    input  logic               ibi_event,
    input  logic               addr_req_event,
    output logic               irq
);

    localparam int THR [NUM_WM] = '{CMD_LOW, RCPT_HIGH, TX_LOW, RX_HIGH, IBI_HIGH};

    logic [LVL_W-1:0]    lvl_arr [NUM_WM];
    logic [NUM_SRC-1:0]  src_vec;
    logic [NUM_SRC-1:0]  mask_q;
    logic [NUM_SRC-1:0]  pend_vec;
    logic [NUM_FLAG-1:0] flag_set;
    logic [NUM_FLAG-1:0] flag_clr;
    logic                wr_mask;
    logic                wr_pend;
    logic                irq_q;

    // gather the level inputs in source bit order
    always_comb begin
        lvl_arr[B_CMD_LOW]   = cmd_level;
        lvl_arr[B_RCPT_HIGH] = rcpt_level;
        lvl_arr[B_TX_LOW]    = tx_level;
        lvl_arr[B_RX_HIGH]   = rx_level;
        lvl_arr[B_IBI_HIGH]  = ibi_level;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WM; gi++) begin : g_wm
            intr_wm_cmp #(
                .LVL_W  (LVL_W),
                .THRESH (LVL_W'(THR[gi])),
                .ABOVE  (WM_ABOVE[gi])
            ) u_wm (
                .clk   (clk),
                .rst_n (rst_n),
                .level (lvl_arr[gi]),
                .hit_q (src_vec[gi])
            );
        end
    endgenerate

    // decode the register writes
    always_comb begin
        wr_mask = reg_wr && (reg_addr == VIEW_MASK);
        wr_pend = reg_wr && (reg_addr == VIEW_PEND);
    end

    // set and clear terms of the sticky flags, in source bit order
    always_comb begin
        flag_set = {addr_req_event, ibi_event, rcpt_event};
        flag_clr[B_RCPT_FLAG-NUM_WM] = wr_pend && reg_wdata[B_RCPT_FLAG] && rcpt_empty;
        flag_clr[B_IBI_FLAG-NUM_WM]  = wr_pend && reg_wdata[B_IBI_FLAG] && ibi_empty;
        flag_clr[B_ADDR_FLAG-NUM_WM] = !tx_empty;
    end

    generate
        for (gi = 0; gi < NUM_FLAG; gi++) begin : g_flag
            intr_evt_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (flag_set[gi]),
                .clr_i  (flag_clr[gi]),
                .flag_q (src_vec[NUM_WM+gi])
            );
        end
    endgenerate

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata;
    end

    // gate the sources with their enables
    always_comb pend_vec = src_vec & mask_q;

    // registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend_vec;
    end

    assign irq = irq_q;

    // read mux over the three views
    always_comb begin
        case (reg_addr)
            VIEW_SRC:  reg_rdata = src_vec;
            VIEW_MASK: reg_rdata = mask_q;
            VIEW_PEND: reg_rdata = pend_vec;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intr_collector_chk.sv
// Temporal checks on the interrupt collector, bound into every instance.
// Assumes inputs are defined at each sampling edge after reset release.
module intr_collector_chk #(
    parameter int LVL_W     = 6,
    parameter int CMD_LOW   = 4,
    parameter int RCPT_HIGH = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       src_vec,
    input logic [7:0]       mask_q,
    input logic             irq,
    input logic [LVL_W-1:0] cmd_level,
    input logic [LVL_W-1:0] rcpt_level,
    input logic             rcpt_empty,
    input logic             tx_empty,
    input logic             rcpt_event,
    input logic             addr_req_event
);

    localparam logic [LVL_W-1:0] CMD_T  = LVL_W'(CMD_LOW);
    localparam logic [LVL_W-1:0] RCPT_T = LVL_W'(RCPT_HIGH);

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(src_vec & mask_q)));

    // R10
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |=> !irq);

    // R3
    cmd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> src_vec[0] == ($past(cmd_level) < CMD_T));

    // R4
    rcpt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> src_vec[1] == ($past(rcpt_level) > RCPT_T));

    // R7
    rcpt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcpt_event |=> src_vec[5]);

    // R6
    rcpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_vec[5] && !rcpt_empty) |=> src_vec[5]);

    // R8
    addr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_req_event && !tx_empty) |=> !src_vec[7]);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_vec[7] && tx_empty) |=> src_vec[7]);

endmodule

bind intr_collector intr_collector_chk #(
    .LVL_W     (LVL_W),
    .CMD_LOW   (CMD_LOW),
    .RCPT_HIGH (RCPT_HIGH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_vec        (src_vec),
    .mask_q         (mask_q),
    .irq            (irq),
    .cmd_level      (cmd_level),
    .rcpt_level     (rcpt_level),
    .rcpt_empty     (rcpt_empty),
    .tx_empty       (tx_empty),
    .rcpt_event     (rcpt_event),
    .addr_req_event (addr_req_event)
);

// File: tb/intr_collector_bench.sv
`timescale 1ns/100ps
// Bench for the interrupt collector: a behavioural reference model compared
// on every falling edge, plus directed checks with fixed expected values.
module intr_collector_bench;

    localparam int LVL_W     = 6;
    localparam int CMD_LOW   = 4;
    localparam int RCPT_HIGH = 28;
    localparam int TX_LOW    = 4;
    localparam int RX_HIGH   = 28;
    localparam int IBI_HIGH  = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [LVL_W-1:0] cmd_level = 6'd10, rcpt_level = 6'd10, tx_level = 6'd10;
    logic [LVL_W-1:0] rx_level = 6'd10, ibi_level = 6'd10;
    logic rcpt_empty = 1'b1, ibi_empty = 1'b1, tx_empty = 1'b1;
    logic rcpt_event = 1'b0, ibi_event = 1'b0, addr_req_event = 1'b0;
    logic irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R2";

    // reference model state
    logic [7:0] m_src = 8'h00, m_mask = 8'h00, m_nsrc;
    logic m_irq = 1'b0, m_nirq, m_wrp;

    always #2 clk = ~clk;

    intr_collector #(
        .LVL_W(LVL_W), .CMD_LOW(CMD_LOW), .RCPT_HIGH(RCPT_HIGH),
        .TX_LOW(TX_LOW), .RX_HIGH(RX_HIGH), .IBI_HIGH(IBI_HIGH)
    ) u_intr_collector (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_level(cmd_level), .rcpt_level(rcpt_level), .tx_level(tx_level),
        .rx_level(rx_level), .ibi_level(ibi_level),
        .rcpt_empty(rcpt_empty), .ibi_empty(ibi_empty), .tx_empty(tx_empty),
        .rcpt_event(rcpt_event), .ibi_event(ibi_event),
        .addr_req_event(addr_req_event), .irq(irq)
    );

    // behavioural model of the requirements, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 8'h00; m_mask = 8'h00; m_irq = 1'b0;
        end else begin
            m_nirq = |(m_src & m_mask);
            m_wrp = reg_wr && (reg_addr == 2'd2);
            m_nsrc[0] = (int'(cmd_level) < CMD_LOW);
            m_nsrc[1] = (int'(rcpt_level) > RCPT_HIGH);
            m_nsrc[2] = (int'(tx_level) < TX_LOW);
            m_nsrc[3] = (int'(rx_level) > RX_HIGH);
            m_nsrc[4] = (int'(ibi_level) > IBI_HIGH);
            if (rcpt_event) m_nsrc[5] = 1'b1;
            else if (m_wrp && reg_wdata[5] && rcpt_empty) m_nsrc[5] = 1'b0;
            else m_nsrc[5] = m_src[5];
            if (ibi_event) m_nsrc[6] = 1'b1;
            else if (m_wrp && reg_wdata[6] && ibi_empty) m_nsrc[6] = 1'b0;
            else m_nsrc[6] = m_src[6];
            if (addr_req_event) m_nsrc[7] = 1'b1;
            else if (!tx_empty) m_nsrc[7] = 1'b0;
            else m_nsrc[7] = m_src[7];
            if (reg_wr && (reg_addr == 2'd1)) m_mask = reg_wdata;
            m_src = m_nsrc;
            m_irq = m_nirq;
        end
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_src;
            2'd1: return m_mask;
            2'd2: return m_src & m_mask;
            default: return 8'h00;
        endcase
    endfunction

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (irq !== m_irq) begin
                failures++;
                $display("FAIL %s model irq actual=%0b expected=%0b t=%0t", cur_req, irq, m_irq, $time);
            end
            checks++;
            if (reg_rdata !== model_rd(reg_addr)) begin
                failures++;
                $display("FAIL %s model rdata addr=%0d actual=%02h expected=%02h t=%0t",
                         cur_req, reg_addr, reg_rdata, model_rd(reg_addr), $time);
            end
        end
    end

    // watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic at_drive();
        @(negedge clk); #1;
    endtask

    task automatic dir_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        at_drive();
        reg_addr = a;
        #0.5;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s read addr=%0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        at_drive();
        #0.5;
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        at_drive();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        at_drive();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        chk_on = 1'b1;
        repeat (2) @(posedge clk);
        at_drive();
        rst_n = 1'b1;

        // R2: reset state
        cur_req = "R2";
        chk_irq(1'b0, "R2");
        dir_rd(2'd1, 8'h00, "R2");
        dir_rd(2'd0, 8'h00, "R2");

        // R1: unused view reads zero
        cur_req = "R1";
        dir_rd(2'd3, 8'h00, "R1");

        // R3: below-threshold watermarks, boundary at equality
        cur_req = "R3";
        at_drive(); cmd_level = 6'd3;
        dir_rd(2'd0, 8'h01, "R3");
        at_drive(); cmd_level = 6'd4;
        dir_rd(2'd0, 8'h00, "R3");
        at_drive(); tx_level = 6'd0;
        dir_rd(2'd0, 8'h04, "R3");
        at_drive(); tx_level = 6'd10;

        // R4: above-threshold watermarks, boundary at equality
        cur_req = "R4";
        at_drive(); rcpt_level = 6'd29;
        dir_rd(2'd0, 8'h02, "R4");
        at_drive(); rcpt_level = 6'd28;
        dir_rd(2'd0, 8'h00, "R4");
        at_drive(); rx_level = 6'd63; ibi_level = 6'd29;
        dir_rd(2'd0, 8'h18, "R4");
        at_drive(); rx_level = 6'd10; ibi_level = 6'd10;

        // R9: enable register and pending view
        cur_req = "R9";
        reg_write(2'd1, 8'hA5);
        dir_rd(2'd1, 8'hA5, "R9");
        at_drive(); cmd_level = 6'd0; rx_level = 6'd63;
        dir_rd(2'd2, 8'h01, "R9");

        // R10: registered OR of pending, blocked by zero enables
        cur_req = "R10";
        chk_irq(1'b1, "R10");
        reg_write(2'd1, 8'h00);
        chk_irq(1'b0, "R10");
        at_drive(); cmd_level = 6'd10; rx_level = 6'd10;

        // R5: event flags set
        cur_req = "R5";
        reg_write(2'd1, 8'hE0);
        at_drive(); rcpt_event = 1'b1;
        at_drive(); rcpt_event = 1'b0;
        dir_rd(2'd0, 8'h20, "R5");
        at_drive(); ibi_event = 1'b1;
        at_drive(); ibi_event = 1'b0;
        dir_rd(2'd0, 8'h60, "R5");

        // R6: acknowledge qualified by an empty FIFO
        cur_req = "R6";
        at_drive(); rcpt_empty = 1'b0;
        reg_write(2'd2, 8'h20);
        dir_rd(2'd0, 8'h60, "R6");
        at_drive(); rcpt_empty = 1'b1;
        reg_write(2'd2, 8'h20);
        dir_rd(2'd0, 8'h40, "R6");
        reg_write(2'd2, 8'h40);
        dir_rd(2'd0, 8'h00, "R6");

        // R7: event beats a same-edge clear
        cur_req = "R7";
        at_drive(); rcpt_event = 1'b1;
        at_drive(); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h20;
        at_drive(); reg_wr = 1'b0; rcpt_event = 1'b0;
        dir_rd(2'd0, 8'h20, "R7");
        reg_write(2'd2, 8'h20);
        dir_rd(2'd0, 8'h00, "R7");

        // R8: address-request flag clears only on outgoing data present
        cur_req = "R8";
        at_drive(); addr_req_event = 1'b1;
        at_drive(); addr_req_event = 1'b0;
        dir_rd(2'd0, 8'h80, "R8");
        reg_write(2'd2, 8'h80);
        dir_rd(2'd0, 8'h80, "R8");
        at_drive(); cmd_level = 6'd0;
        reg_write(2'd2, 8'h1F);
        dir_rd(2'd0, 8'h81, "R8");
        at_drive(); tx_empty = 1'b0;
        dir_rd(2'd0, 8'h01, "R8");
        cur_req = "R7";
        at_drive(); addr_req_event = 1'b1;
        dir_rd(2'd0, 8'h81, "R7");
        at_drive(); addr_req_event = 1'b0;
        dir_rd(2'd0, 8'h01, "R8");
        at_drive(); tx_empty = 1'b1; cmd_level = 6'd10;

        // R9 and R10 under random traffic, checked against the model
        cur_req = "R9";
        for (int i = 0; i < 600; i++) begin
            at_drive();
            cmd_level      = 6'($urandom_range(63, 0));
            rcpt_level     = 6'($urandom_range(63, 0));
            tx_level       = 6'($urandom_range(63, 0));
            rx_level       = 6'($urandom_range(63, 0));
            ibi_level      = 6'($urandom_range(63, 0));
            rcpt_empty     = ($urandom_range(1, 0) == 0);
            ibi_empty      = ($urandom_range(1, 0) == 0);
            tx_empty       = ($urandom_range(3, 0) != 0);
            rcpt_event     = ($urandom_range(5, 0) == 0);
            ibi_event      = ($urandom_range(5, 0) == 0);
            addr_req_event = ($urandom_range(5, 0) == 0);
            reg_wr         = ($urandom_range(2, 0) == 0);
            reg_addr       = 2'($urandom_range(3, 0));
            reg_wdata      = 8'($urandom_range(255, 0));
        end
        at_drive(); reg_wr = 1'b0;
        at_drive();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule